// File: doc/BRIEF.md
# Warp Barrier Synchronization Unit

This unit keeps a bank of numbered rendezvous points for a core that runs several warps. A warp reaching a synchronization instruction presents one arrival: which barrier it targets, how many warps must meet there, and its own warp number. The unit remembers which warps have arrived at each barrier. For every arrival it answers, one clock later, whether the arriving warp must be parked or whether the meeting is complete.

Each barrier is a bitmask with one bit per warp. An arrival ORs in its own bit, counts the set bits of the result and compares that count with the requested participant count. If the count is still short, the warp is told to suspend. Otherwise a release mask naming every recorded warp, the arriving one included, is returned and the barrier is emptied for reuse. The scheduler that parks and wakes warps, and the decoder that produces the arrival, sit outside this block.

Top module: `warp_rendezvous`

## Requirements
- R1: An arrival records the arriving warp in the selected barrier, so a later completing arrival at that barrier includes it in `rsp_release` (bit i of `rsp_release` stands for warp i).
- R2: When the number of recorded warps after the arrival is below `arr_count`, the response has `rsp_suspend`=1 and `rsp_release`=0.
- R3: When the number of recorded warps after the arrival is at least `arr_count`, the response has `rsp_suspend`=0 and `rsp_release` equal to exactly the recorded warps, the arriving warp included.
- R4: A completing arrival empties the barrier, so the next arrival there counts from one.
- R5: A synchronous active-high reset empties every barrier and drives `rsp_valid`, `rsp_suspend` and `rsp_release` to 0.
- R6: An arrival from a warp already recorded at that barrier does not raise its count.
- R7: An `arr_count` of 0 or 1 releases the arriving warp (plus any already recorded) at once, without a suspend.
- R8: The response to an arrival presented at a rising edge appears on the outputs right after that edge with `rsp_valid`=1; after an edge with no arrival, `rsp_valid`, `rsp_suspend` and `rsp_release` are all 0.
- R9: Barriers are independent: an arrival at one barrier leaves the recorded warps of every other barrier unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arr_valid | input | 1 | An arrival is presented this cycle |
| arr_bar | input | BAR_W | Barrier number |
| arr_count | input | CNT_W | Number of warps required to complete |
| arr_warp | input | WID_W | Number of the arriving warp |
| rsp_valid | output | 1 | Response to the previous cycle's arrival |
| rsp_suspend | output | 1 | Arriving warp must be parked |
| rsp_release | output | NUM_WARPS | Warps to reactivate (one bit per warp) |

## Verification
A wrong stored bitmask is invisible until a barrier completes, so the bench drives long mixed sequences in which every barrier completes many times under varying counts and warp orders, and compares each response against an arithmetic model of the bitmasks. A lost or spurious bit then shows either as a release mask that differs from the model or as a suspend/release decision flipped on the first arrival whose count depends on it, normally within a handful of arrivals. Reset in the middle of a partial barrier, repeated arrivals and zero/one counts are exercised directly.

// File: rtl/wbar_pkg.sv
package wbar_pkg;
  // Width of an index into n items, at least one bit.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Width able to hold the value n itself.
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wbar_popcount.sv
module wbar_popcount #(
  parameter int N     = 4,
  parameter int OUT_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic [OUT_W-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) begin
      ones = ones + OUT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/wbar_mask_bank.sv
module wbar_mask_bank #(
  parameter int NUM_BARS  = 4,
  parameter int NUM_WARPS = 4,
  parameter int BAR_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [BAR_W-1:0]     rd_idx,
  output logic [NUM_WARPS-1:0] rd_mask,
  input  logic                 wr_en,
  input  logic [BAR_W-1:0]     wr_idx,
  input  logic [NUM_WARPS-1:0] wr_mask
);
  logic [NUM_WARPS-1:0] mask_q [NUM_BARS];

  assign rd_mask = mask_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BARS; b++) mask_q[b] <= '0;
    end else if (wr_en) begin
      mask_q[wr_idx] <= wr_mask;
    end
  end

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_chk
      // R5: every barrier is empty after a reset cycle
      a_r5_reset_empties: assert property (@(posedge clk)
        $past(rst) |-> (mask_q[g] == '0));
      // R9: an entry changes only when it is the written one
      a_r9_other_untouched: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_idx != BAR_W'(g)) |=> $stable(mask_q[g]));
    end
  endgenerate
endmodule

// File: rtl/wbar_arrive_eval.sv
module wbar_arrive_eval #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic [NUM_WARPS-1:0] cur_mask,
  input  logic [WID_W-1:0]     warp,
  input  logic [CNT_W-1:0]     need,
  output logic [NUM_WARPS-1:0] merged,
  output logic                 complete
);
  logic [CNT_W-1:0] present;

  assign merged = cur_mask | (NUM_WARPS'(1) << warp);

  wbar_popcount #(.N(NUM_WARPS), .OUT_W(CNT_W)) u_pop (
    .vec  (merged),
    .ones (present)
  );

  assign complete = (present >= need);
endmodule

// File: rtl/warp_rendezvous.sv
module warp_rendezvous #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_BARS  = 4,
  parameter int WID_W     = wbar_pkg::idx_width(NUM_WARPS),
  parameter int BAR_W     = wbar_pkg::idx_width(NUM_BARS),
  parameter int CNT_W     = wbar_pkg::cnt_width(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arr_valid,
  input  logic [BAR_W-1:0]     arr_bar,
  input  logic [CNT_W-1:0]     arr_count,
  input  logic [WID_W-1:0]     arr_warp,
  output logic                 rsp_valid,
  output logic                 rsp_suspend,
  output logic [NUM_WARPS-1:0] rsp_release
);
  logic [NUM_WARPS-1:0] cur_mask;
  logic [NUM_WARPS-1:0] merged;
  logic                 complete;
  logic [NUM_WARPS-1:0] next_store;

  wbar_mask_bank #(.NUM_BARS(NUM_BARS), .NUM_WARPS(NUM_WARPS), .BAR_W(BAR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (arr_bar),
    .rd_mask (cur_mask),
    .wr_en   (arr_valid),
    .wr_idx  (arr_bar),
    .wr_mask (next_store)
  );

  wbar_arrive_eval #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .CNT_W(CNT_W)) u_eval (
    .cur_mask (cur_mask),
    .warp     (arr_warp),
    .need     (arr_count),
    .merged   (merged),
    .complete (complete)
  );

  assign next_store = complete ? '0 : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_suspend <= 1'b0;
      rsp_release <= '0;
    end else begin
      rsp_valid   <= arr_valid;
      rsp_suspend <= arr_valid && !complete;
      rsp_release <= (arr_valid && complete) ? merged : '0;
    end
  end

  // R2: a parked warp never comes with a release
  a_r2_suspend_no_release: assert property (@(posedge clk) disable iff (rst)
    rsp_suspend |-> (rsp_release == '0));
  // R3: a completion always wakes the warp that completed it
  a_r3_release_has_arriver: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_suspend) |-> rsp_release[$past(arr_warp)]);
  // R7: a count of zero or one never parks
  a_r7_low_count_free: assert property (@(posedge clk) disable iff (rst)
    (arr_valid && arr_count <= CNT_W'(1)) |=> !rsp_suspend);
  // R8: outputs are quiet after a cycle with no arrival
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !arr_valid |=> (!rsp_valid && !rsp_suspend && rsp_release == '0));
  // R8: every arrival gets a response on the next cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    arr_valid |=> rsp_valid);
endmodule

// File: tb/tb_warp_rendezvous.sv
module tb_warp_rendezvous;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NB = 4;
  localparam int WID_W = 2;
  localparam int BAR_W = 2;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rst;
  logic             arr_valid;
  logic [BAR_W-1:0] arr_bar;
  logic [CNT_W-1:0] arr_count;
  logic [WID_W-1:0] arr_warp;
  logic             rsp_valid;
  logic             rsp_suspend;
  logic [NW-1:0]    rsp_release;

  warp_rendezvous #(.NUM_WARPS(NW), .NUM_BARS(NB)) dut (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_bar(arr_bar),
    .arr_count(arr_count), .arr_warp(arr_warp), .rsp_valid(rsp_valid),
    .rsp_suspend(rsp_suspend), .rsp_release(rsp_release)
  );

  int total = 0;
  int bad = 0;
  logic [NW-1:0] model [NB];

  task automatic check(input string req, input logic [NW+1:0] act, input logic [NW+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {valid,suspend,release} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    arr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < NB; b++) model[b] = '0;
  endtask

  // Drive one arrival, compare the response with the model.
  task automatic arrive(input int b, input int c, input int w, input string tag);
    logic [NW-1:0] nm;
    logic sus;
    logic [NW-1:0] rel;
    string req;
    @(negedge clk);
    arr_valid = 1'b1;
    arr_bar   = BAR_W'(b);
    arr_count = CNT_W'(c);
    arr_warp  = WID_W'(w);
    nm = model[b] | (NW'(1) << w);
    if (model[b][w]) req = "R6";
    else if (c <= 1) req = "R7";
    else if ($countones(nm) >= c) req = "R3";
    else req = "R2";
    if (tag != "") req = tag;
    if ($countones(nm) >= c) begin
      sus = 1'b0; rel = nm; model[b] = '0;
    end else begin
      sus = 1'b1; rel = '0; model[b] = nm;
    end
    @(negedge clk);
    arr_valid = 1'b0;
    check(req, {rsp_valid, rsp_suspend, rsp_release}, {1'b1, sus, rel});
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R8 idle", {rsp_valid, rsp_suspend, rsp_release}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    arr_valid = 1'b0;
    arr_bar = '0;
    arr_count = '0;
    arr_warp = '0;
    for (int b = 0; b < NB; b++) model[b] = '0;
    do_reset();
    check("R5 reset outputs", {rsp_valid, rsp_suspend, rsp_release}, '0);

    // R1/R3: four warps meet at barrier 2, last one wakes all
    arrive(2, 4, 3, "R2");
    arrive(2, 4, 0, "R2");
    arrive(2, 4, 1, "R2");
    arrive(2, 4, 2, "R1 R3 full mask");
    idle_check();
    // R4: barrier 2 starts over after completion
    arrive(2, 2, 1, "R4 fresh count");
    arrive(2, 2, 3, "R4 R3");
    // R6: repeated arrival does not advance
    arrive(0, 2, 2, "R2");
    arrive(0, 2, 2, "R6 repeat");
    arrive(0, 2, 0, "R6 R3");
    // R7: counts 0 and 1
    arrive(1, 0, 3, "R7 count0");
    arrive(1, 1, 2, "R7 count1");
    arrive(3, 3, 1, "R2");
    arrive(3, 1, 0, "R7 joins recorded");
    // R9: partial barriers stay independent
    arrive(0, 3, 0, "R2");
    arrive(1, 3, 1, "R2");
    arrive(2, 3, 2, "R2");
    arrive(1, 3, 3, "R9 R2");
    arrive(0, 3, 3, "R9 R2");
    arrive(0, 3, 1, "R9 R3");
    arrive(1, 3, 0, "R9 R3");
    arrive(2, 2, 0, "R9 R3");
    // R5: reset in the middle of a partial barrier
    arrive(3, 2, 2, "R2");
    do_reset();
    arrive(3, 2, 1, "R5 cleared");
    arrive(3, 2, 0, "R5 R3");
    // counts above what can be reached stay parked
    arrive(1, 5, 0, "R2 oversize");
    arrive(1, 5, 1, "R2 oversize");
    do_reset();

    // near-exhaustive sweep
    for (int i = 0; i < 3000; i++) begin
      arrive((i * 7 + i / 11) % NB, (i / 3) % 6, (i * 3 + i / 5) % NW, "");
      if (i % 97 == 0) idle_check();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule